// File: doc/BRIEF.md
# DMA Channel Request Scheduler

This block picks the DMA channel that may move its next element. Each channel presents a 32-bit configuration word and a 32-bit control word. The configuration word supplies an enable bit, a halt bit, a flow-type code, and a source and a destination peripheral number. The low field of the control word is the count of elements still to move. The scheduler merges the single-element and burst request vectors from up to 32 peripherals. From these inputs it decides which channels are eligible and registers a one-hot grant for one of them.

Arbitration is sticky. A granted channel keeps the grant on every edge at which it is still eligible, even if a lower-numbered channel has become eligible meanwhile. When the granted channel drops out, or nothing is granted, the lowest-numbered eligible channel wins. Two further conditions are reported. A controller-wide enable input suppresses every grant. A channel that is enabled but asks for a peripheral-controlled flow type is flagged as unsupported and is never served. The channel count is a build parameter, either 8 or 2. The output vectors are always 8 bits wide.

Top module: `dma_req_sched`

## Requirements
- R1: At most one bit of `grant` is set. Bit i stands for channel i, and bits at or above NUM_CH are always 0.
- R2: A channel can be eligible only when bit 0 (enable) of its configuration word is 1 and bit 18 (halt) is 0.
- R3: The flow type is taken from configuration bits [13:11], the source peripheral number from bits [5:1] and the destination peripheral number from bits [10:6]. A peripheral counts as requesting when its bit is set in either `req_single` or `req_burst`.
- R4: Flow type 0 needs no peripheral request. Type 1 needs the destination's request. Type 2 needs the source's request. Type 3 needs both.
- R5: A channel whose control-word bits [11:0] are zero is not eligible.
- R6: While `ctl_enable` is 0 when sampled, the next `grant` is all zeros.
- R7: A channel with enable 1, halt 0 and flow type 4 to 7 is never granted, and its `unsup_err` bit is set. `unsup_err` bits at or above NUM_CH are 0.
- R8: When no channel is currently granted, or the granted one is no longer eligible, the next grant goes to the lowest-numbered eligible channel.
- R9: A granted channel keeps its grant on every edge at which it is still eligible and `ctl_enable` is 1, whatever lower-numbered channels do.
- R10: `grant` and `unsup_err` are registered and reflect the inputs sampled at the previous rising edge of `clk`. Reset (`rst_n` low) clears both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_enable | input | 1 | Controller-wide enable; 0 blocks every grant |
| chan_cfg | input | NUM_CH*32 | Configuration word of each channel, channel i in bits [32i+31:32i] |
| chan_ctrl | input | NUM_CH*32 | Control word of each channel; bits [11:0] of each word hold the remaining count |
| req_single | input | 32 | Single-element request per peripheral |
| req_burst | input | 32 | Burst request per peripheral |
| grant | output | 8 | Registered one-hot grant, bit i for channel i |
| unsup_err | output | 8 | Registered flag per channel for an unsupported flow type |

## Verification
The main collision is between holding the current grant and a fresh priority scan. A lower-numbered channel can become eligible in the same cycle that a higher-numbered channel is being held, and the held channel's count can reach zero in the same vector in which another channel is waiting. The bench provokes this directly: channel 5 is held, channel 1 is raised, and then channel 5 is dropped while channel 1 stays eligible. A long pseudo-random mix of per-channel changes, request toggles and enable drops repeats the collision many times. Each edge is judged against a bench reference that tracks the held channel. The reference keeps the held channel while it stays eligible and otherwise takes the lowest eligible one. The same stimulus drives a 2-channel build, which must keep its upper grant bits at zero.

// File: rtl/dsch_pkg.sv
package dsch_pkg;

   localparam int CFG_W    = 32;
   localparam int CTRL_W   = 32;
   localparam int REQ_W    = 32;
   localparam int MAX_CH   = 8;
   localparam int CNT_W    = 12;
   localparam int PERI_W   = 5;
   localparam int FLOW_W   = 3;

   localparam int EN_BIT   = 0;
   localparam int HALT_BIT = 18;
   localparam int SRC_LSB  = 1;
   localparam int DST_LSB  = 6;
   localparam int FLOW_LSB = 11;

   typedef enum logic [FLOW_W-1:0] {
      FL_MEM2MEM  = 3'd0,
      FL_TO_DST   = 3'd1,
      FL_FROM_SRC = 3'd2,
      FL_PERI2PER = 3'd3
   } flow_e;

   typedef struct packed {
      logic              en;
      logic              halt;
      logic [FLOW_W-1:0] flow;
      logic [PERI_W-1:0] src;
      logic [PERI_W-1:0] dst;
   } chan_cfg_t;

   function automatic chan_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
      chan_cfg_t c;
      c.en   = w[EN_BIT];
      c.halt = w[HALT_BIT];
      c.flow = w[FLOW_LSB +: FLOW_W];
      c.src  = w[SRC_LSB +: PERI_W];
      c.dst  = w[DST_LSB +: PERI_W];
      return c;
   endfunction

endpackage

// File: rtl/dsch_elig.sv
module dsch_elig
   import dsch_pkg::*;
#(
   parameter int NUM_CH = 8
) (
   input  logic [NUM_CH*CFG_W-1:0]  cfg_flat,
   input  logic [NUM_CH*CTRL_W-1:0] ctrl_flat,
   input  logic [REQ_W-1:0]         req_single,
   input  logic [REQ_W-1:0]         req_burst,
   output logic [NUM_CH-1:0]        elig,
   output logic [NUM_CH-1:0]        unsup
);

   logic [REQ_W-1:0] req_any;
   assign req_any = req_single | req_burst;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      chan_cfg_t c;
      logic      cnt_nz;
      logic      src_rq;
      logic      dst_rq;
      logic      gate;
      logic      live;
      logic      unused_ctrl_hi;

      assign c              = unpack_cfg(cfg_flat[i*CFG_W +: CFG_W]);
      assign cnt_nz         = |ctrl_flat[i*CTRL_W +: CNT_W];
      assign unused_ctrl_hi = ^ctrl_flat[i*CTRL_W+CNT_W +: CTRL_W-CNT_W];
      assign src_rq         = req_any[c.src];
      assign dst_rq         = req_any[c.dst];
      assign live           = c.en & ~c.halt;

      always_comb begin
         case (c.flow)
            FL_MEM2MEM:  gate = 1'b1;
            FL_TO_DST:   gate = dst_rq;
            FL_FROM_SRC: gate = src_rq;
            FL_PERI2PER: gate = src_rq & dst_rq;
            default:     gate = 1'b0;
         endcase
      end

      assign elig[i]  = live & cnt_nz & gate;
      assign unsup[i] = live & c.flow[FLOW_W-1];
   end

endmodule

// File: rtl/dsch_pick.sv
module dsch_pick #(
   parameter int N = 8
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] pick
);

   localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

   if (N == 2) begin : g_two
      assign pick = {req[1] & ~req[0], req[0]};
   end else begin : g_scan
      always_comb begin
         logic found;
         found = 1'b0;
         pick  = '0;
         for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
               pick[i] = 1'b1;
               found   = 1'b1;
            end
         end
      end
   end

   // R8: the chosen bit is requested and nothing below it is
   always_comb begin
      if (pick != '0) begin
         a_r8_pick_lowest : assert (((req & (pick - ONE)) == '0) && ((req & pick) != '0));
      end else begin
         a_r8_pick_none : assert (req == '0);
      end
   end

endmodule

// File: rtl/dsch_hold.sv
module dsch_hold #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         glb_en,
   input  logic [N-1:0] elig,
   input  logic [N-1:0] pick,
   output logic [N-1:0] grant_q
);

   localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

   logic         keep;
   logic [N-1:0] grant_d;

   assign keep = |(grant_q & elig);

   always_comb begin
      if (!glb_en)   grant_d = '0;
      else if (keep) grant_d = grant_q;
      else           grant_d = pick;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) grant_q <= '0;
      else        grant_q <= grant_d;
   end

   a_r1_onehot : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_q));

   a_r6_off_no_grant : assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en |=> (grant_q == '0));

   a_r9_hold_stable : assert property (@(posedge clk) disable iff (!rst_n)
      (glb_en && keep) |=> $stable(grant_q));

   a_r2_granted_was_elig : assert property (@(posedge clk) disable iff (!rst_n)
      glb_en |=> ((grant_q & ~$past(elig)) == '0));

   a_r8_fresh_lowest : assert property (@(posedge clk) disable iff (!rst_n)
      (glb_en && !keep && (elig != '0)) |=>
         ((grant_q != '0) && (($past(elig) & (grant_q - ONE)) == '0)));

endmodule

// File: rtl/dma_req_sched.sv
module dma_req_sched
   import dsch_pkg::*;
#(
   parameter int NUM_CH = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ctl_enable,
   input  logic [NUM_CH*CFG_W-1:0]  chan_cfg,
   input  logic [NUM_CH*CTRL_W-1:0] chan_ctrl,
   input  logic [REQ_W-1:0]         req_single,
   input  logic [REQ_W-1:0]         req_burst,
   output logic [MAX_CH-1:0]        grant,
   output logic [MAX_CH-1:0]        unsup_err
);

   localparam int PAD_W = MAX_CH - NUM_CH;

   if (!(NUM_CH == 8 || NUM_CH == 2)) begin : g_bad_nch
      $error("dma_req_sched: NUM_CH must be 8 or 2");
   end

   logic [NUM_CH-1:0] elig;
   logic [NUM_CH-1:0] unsup;
   logic [NUM_CH-1:0] pick;
   logic [NUM_CH-1:0] grant_q;
   logic [NUM_CH-1:0] unsup_q;

   dsch_elig #(.NUM_CH(NUM_CH)) u_elig (
      .cfg_flat   (chan_cfg),
      .ctrl_flat  (chan_ctrl),
      .req_single (req_single),
      .req_burst  (req_burst),
      .elig       (elig),
      .unsup      (unsup)
   );

   dsch_pick #(.N(NUM_CH)) u_pick (
      .req  (elig),
      .pick (pick)
   );

   dsch_hold #(.N(NUM_CH)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .glb_en  (ctl_enable),
      .elig    (elig),
      .pick    (pick),
      .grant_q (grant_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) unsup_q <= '0;
      else        unsup_q <= unsup;
   end

   if (PAD_W > 0) begin : g_pad
      assign grant     = {{PAD_W{1'b0}}, grant_q};
      assign unsup_err = {{PAD_W{1'b0}}, unsup_q};
   end else begin : g_full
      assign grant     = grant_q;
      assign unsup_err = unsup_q;
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      a_r7_unsup_not_granted : assert property (@(posedge clk) disable iff (!rst_n)
         unsup[i] |=> (!grant[i] && unsup_err[i]));
   end

endmodule

// File: tb/dma_req_sched_bench.sv
module dma_req_sched_bench;

   localparam int NCH = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              en = 1'b1;
   logic [NCH*32-1:0] cfg = '0;
   logic [NCH*32-1:0] ctrl = '0;
   logic [31:0]       rs = '0;
   logic [31:0]       rb = '0;
   logic [7:0]        grant8, uerr8, grant2, uerr2;
   logic [7:0]        exp_g8 = '0;
   logic [7:0]        exp_g2 = '0;
   int                vecs = 0;
   int                miss = 0;
   bit                done = 1'b0;

   always #10 clk = ~clk;

   dma_req_sched #(.NUM_CH(8)) u_dma_req_sched (
      .clk(clk), .rst_n(rst_n), .ctl_enable(en),
      .chan_cfg(cfg), .chan_ctrl(ctrl),
      .req_single(rs), .req_burst(rb),
      .grant(grant8), .unsup_err(uerr8));

   dma_req_sched #(.NUM_CH(2)) u_dma_req_sched_n2 (
      .clk(clk), .rst_n(rst_n), .ctl_enable(en),
      .chan_cfg(cfg[63:0]), .chan_ctrl(ctrl[63:0]),
      .req_single(rs), .req_burst(rb),
      .grant(grant2), .unsup_err(uerr2));

   function automatic logic [31:0] mk_cfg(int e, int h, int fl, int s, int d);
      return 32'(e + s*2 + d*64 + fl*2048 + h*262144);
   endfunction

   function automatic bit m_ch_elig(logic [31:0] w, logic [31:0] c, logic [31:0] rq);
      int fl = int'((w >> 11) & 32'h7);
      int s  = int'((w >> 1) & 32'h1f);
      int d  = int'((w >> 6) & 32'h1f);
      if (w[0] == 1'b0 || w[18] == 1'b1) return 1'b0;
      if ((c & 32'hfff) == 32'h0) return 1'b0;
      case (fl)
         0: return 1'b1;
         1: return rq[d];
         2: return rq[s];
         3: return rq[s] & rq[d];
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [7:0] m_elig(int n);
      logic [7:0] v = '0;
      for (int i = 0; i < n; i++) v[i] = m_ch_elig(cfg[i*32 +: 32], ctrl[i*32 +: 32], rs | rb);
      return v;
   endfunction

   function automatic logic [7:0] m_unsup(int n);
      logic [7:0] v = '0;
      for (int i = 0; i < n; i++) begin
         logic [31:0] w = cfg[i*32 +: 32];
         v[i] = w[0] && !w[18] && (((w >> 11) & 32'h7) >= 32'h4);
      end
      return v;
   endfunction

   function automatic logic [7:0] m_next(logic [7:0] cur, logic [7:0] el, bit e);
      if (!e) return 8'h00;
      if ((cur & el) != 8'h00) return cur;
      for (int i = 0; i < 8; i++) if (el[i]) return 8'(1 << i);
      return 8'h00;
   endfunction

   task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
      vecs++;
      if (act !== exp) begin
         miss++;
         $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic step(input string tag);
      logic [7:0] eu8, eu2;
      eu8 = m_unsup(8);
      eu2 = m_unsup(2);
      exp_g8 = m_next(exp_g8, m_elig(8), en);
      exp_g2 = m_next(exp_g2, m_elig(2), en);
      @(posedge clk);
      @(negedge clk);
      check(tag, "grant(8ch)", grant8, exp_g8);
      check(tag, "unsup(8ch)", uerr8, eu8);
      check(tag, "grant(2ch)", grant2, exp_g2);
      check(tag, "unsup(2ch)", uerr2, eu2);
      check("R1", "grant(2ch) upper bits", {2'b00, grant2[7:2]}, 8'h00);
      check("R7", "unsup(2ch) upper bits", {2'b00, uerr2[7:2]}, 8'h00);
   endtask

   task automatic set_ch(input int i, input logic [31:0] w, input logic [31:0] c);
      cfg[i*32 +: 32]  = w;
      ctrl[i*32 +: 32] = c;
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         miss++;
         $display("FAIL watchdog: actual hung expected finish");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] lf;
      string       tg;

      // R10: reset clears outputs even with eligible and unsupported inputs
      set_ch(0, mk_cfg(1, 0, 0, 0, 0), 32'd4);
      set_ch(1, mk_cfg(1, 0, 5, 0, 0), 32'd4);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R10", "grant in reset", grant8, 8'h00);
      check("R10", "unsup in reset", uerr8, 8'h00);
      check("R10", "grant2 in reset", grant2, 8'h00);
      cfg = '0; ctrl = '0;
      rst_n = 1'b1;
      step("R10");

      // Channel 0 sweep across flow, enable/halt, count, requests
      for (int fl = 0; fl < 8; fl++)
         for (int eh = 0; eh < 4; eh++)
            for (int cz = 0; cz < 2; cz++)
               for (int rq = 0; rq < 4; rq++)
                  for (int via = 0; via < 2; via++) begin
                     logic [31:0] r;
                     set_ch(0, mk_cfg(eh & 1, eh >> 1, fl, 3, 17), (cz != 0) ? 32'hfffff000 : 32'h00000005);
                     r = ((rq & 1) != 0 ? 32'h8 : 32'h0) | ((rq & 2) != 0 ? 32'h20000 : 32'h0);
                     rs = (via == 0) ? r : 32'h0;
                     rb = (via == 1) ? r : 32'h0;
                     if (eh != 1)      tg = "R2";
                     else if (cz != 0) tg = "R5";
                     else if (fl >= 4) tg = "R7";
                     else if (via != 0) tg = "R3";
                     else              tg = "R4";
                     step(tg);
                  end
      rs = '0; rb = '0;

      // R8: every eligibility mask from an idle start
      for (int m = 0; m < 256; m++) begin
         cfg = '0; ctrl = '0;
         step("R8");
         for (int i = 0; i < 8; i++)
            if (((m >> i) & 1) != 0) set_ch(i, mk_cfg(1, 0, 0, 0, 0), 32'd1);
         step("R8");
      end

      // R9: held channel 5 versus a newly eligible channel 1
      cfg = '0; ctrl = '0;
      step("R9");
      set_ch(5, mk_cfg(1, 0, 2, 9, 0), 32'd3);
      rs = 32'h200;
      step("R9");
      set_ch(1, mk_cfg(1, 0, 0, 0, 0), 32'd3);
      step("R9");
      step("R9");
      rs = 32'h0;
      step("R9");
      step("R9");

      // R6: global enable off and back on
      set_ch(3, mk_cfg(1, 0, 0, 0, 0), 32'd2);
      en = 1'b0;
      step("R6");
      step("R6");
      en = 1'b1;
      step("R6");

      // R7: unsupported flow types on several channels
      cfg = '0; ctrl = '0;
      set_ch(0, mk_cfg(1, 0, 4, 0, 0), 32'd1);
      set_ch(1, mk_cfg(1, 0, 7, 0, 0), 32'd1);
      set_ch(6, mk_cfg(1, 1, 6, 0, 0), 32'd1);
      set_ch(7, mk_cfg(1, 0, 0, 0, 0), 32'd1);
      step("R7");
      step("R7");

      // Mixed pseudo-random traffic
      lf = 32'h1ace_b00c;
      for (int k = 0; k < 3000; k++) begin
         int ch, fl;
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         ch = int'(lf[2:0]);
         fl = int'(lf[5:3]);
         if (lf[6]) fl = fl & 3;
         set_ch(ch, mk_cfg(int'(lf[7] | lf[8]), int'(lf[9] & lf[10]), fl,
                           int'(lf[15:11]), int'(lf[20:16])),
                (lf[23:22] != 2'b00) ? 32'd7 : 32'd0);
         rs = lf;
         rb = {lf[15:0], lf[31:16]} & 32'h0f0f0f0f;
         en = (lf[30:28] != 3'b000);
         step((k % 2 == 0) ? "R8" : "R9");
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule